// File: doc/BRIEF.md
# Accumulator Instruction Sequencer

This block is a 16-bit accumulator processor core that walks every instruction through a fixed chain of timing steps. A step counter, held as an enumerated state (`ST_T0` to `ST_T6`), chooses the register transfer done in each clock. During fetch, the address register takes the program counter, and then the instruction register takes the word at that address while the program counter advances. During decode, the 3-bit opcode becomes a one-hot vector, the address field goes to the address register and the top bit goes to the indirect flag. An optional indirect step and the per-opcode execute steps follow.

The core holds its program and data in an internal word memory. The memory is written through a preload port while reset is asserted, and a combinational peek port reads it. An 8-bit input port fills an input holding register and raises an input-ready flag. An 8-bit output register is read by the consumer, which returns it to the core by pulsing an acknowledge that raises an output-ready flag. The state transitions are:

- `ST_T0`→`ST_T1`→`ST_T2`→`ST_T3` on every instruction.
- `ST_T3`→`ST_T0` when the opcode is 7.
- `ST_T3`→`ST_T4` for all other opcodes.
- `ST_T4`→`ST_T0` for store and jump.
- `ST_T4`→`ST_T5` for all other memory opcodes.
- `ST_T5`→`ST_T6` for increment-and-skip.
- `ST_T5`→`ST_T0` for all other memory opcodes.
- `ST_T6`→`ST_T0`.

Reset holds the state at `ST_T0`.

Top module: `acc_seq_core`

## Requirements
- R1: A synchronous high `rst` clears the program counter, accumulator, carry bit, interrupt enable and both I/O flags, and holds the sequence at its fetch step (`fetch_q`=1).
- R2: Every instruction starts with three fixed steps. Step one copies PC to the address register. Step two loads the instruction word from memory and increments PC. Step three decodes it. Instruction word layout: bit 15 is the indirect flag, bits 14:12 are the opcode, and bits 11:0 are the address.
- R3: Opcode 0 (AND), opcode 1 (ADD) and opcode 2 (LOAD) read the operand and update the accumulator with AND, sum or copy. ADD puts its carry-out in the carry bit. Each of these takes 6 cycles.
- R4: With the indirect flag set, a memory-reference instruction replaces its address with the low 12 bits of the word at that address before executing.
- R5: Opcode 3 (STORE) writes the accumulator to memory and takes 5 cycles. Opcode 4 (JUMP) loads PC with the address and takes 5 cycles.
- R6: Opcode 5 (CALL) writes the return PC at the address and then sets PC to address+1. It takes 6 cycles.
- R7: Opcode 6 (increment-and-skip) writes the incremented word back and skips the next instruction when the result is zero. It takes 7 cycles.
- R8: Opcode 7 with indirect flag 0 changes nothing but PC (+1) and takes 4 cycles.
- R9: Opcode 7 with indirect flag 1 and bit 11 set (word 0xF800) copies the input register to accumulator bits 7:0, keeps bits 15:8, and clears the input flag. An `in_valid` pulse captures `in_byte` and sets the flag.
- R10: Word 0xF400 (bit 10) copies accumulator bits 7:0 to `out_byte` and clears the output flag. An `out_ack` pulse sets that flag.
- R11: Word 0xF200 (bit 9) skips the next instruction when the input flag is 1. Word 0xF100 (bit 8) does the same with the output flag. With the flag clear, neither skips. Each takes 4 cycles.
- R12: Word 0xF080 (bit 7) sets the interrupt enable, which stays set until reset.
- R13: Step `ST_T6` is always followed by `ST_T0`. No instruction runs longer than 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pre_we | input | 1 | Preload write strobe, used only during reset |
| pre_addr | input | AW | Preload word address |
| pre_data | input | DW | Preload word |
| peek_addr | input | AW | Memory observation address |
| peek_data | output | DW | Word at `peek_addr` (combinational) |
| in_valid | input | 1 | Input byte strobe; sets input flag |
| in_byte | input | IOW | Input byte |
| out_ack | input | 1 | Consumer took output; sets output flag |
| out_byte | output | IOW | Output register |
| in_flag | output | 1 | Input-ready flag |
| out_flag | output | 1 | Output-ready flag |
| ac_q | output | DW | Accumulator |
| pc_q | output | DW-4 | Program counter |
| e_q | output | 1 | Carry bit |
| ien_q | output | 1 | Interrupt enable |
| fetch_q | output | 1 | High when the sequence is at step `ST_T0` |

## Verification
The bench checks the cycle count of each instruction class at the instruction boundary.

- A sequencer that skips or adds a step shows the wrong PC or a low `fetch_q` at that boundary.
- An ADD that overflows must set the carry bit.
- An indirect load is compared against a direct one, so a missing address step returns the pointer instead of the operand.
- Increment-and-skip is run once with a word that wraps to zero and once with one that does not, so a design that always or never skips is caught.
- The skip-on-flag instructions run with each flag clear and then set.
- The input instruction must leave the accumulator's upper byte alone; a design that cleared it would fail.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
    localparam int OPW  = 3;
    localparam int NDEC = 1 << OPW;

    typedef enum logic [2:0] {
        ST_T0, ST_T1, ST_T2, ST_T3, ST_T4, ST_T5, ST_T6
    } seq_t;

    // opcode positions in the one-hot decode
    localparam int OP_AND = 0;
    localparam int OP_ADD = 1;
    localparam int OP_LDA = 2;
    localparam int OP_STA = 3;
    localparam int OP_JMP = 4;
    localparam int OP_CAL = 5;
    localparam int OP_ISZ = 6;
    localparam int OP_EXT = 7;

    // I/O select bits inside the address field
    localparam int IO_INP = 11;
    localparam int IO_OUT = 10;
    localparam int IO_SKI = 9;
    localparam int IO_SKO = 8;
    localparam int IO_ION = 7;
endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
    import acc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NDEC-1:0] dec,
    output seq_t            st
);
    seq_t st_nxt;

    always_comb begin
        case (st)
            ST_T0:   st_nxt = ST_T1;
            ST_T1:   st_nxt = ST_T2;
            ST_T2:   st_nxt = ST_T3;
            ST_T3:   st_nxt = dec[OP_EXT] ? ST_T0 : ST_T4;
            ST_T4:   st_nxt = (dec[OP_STA] || dec[OP_JMP]) ? ST_T0 : ST_T5;
            ST_T5:   st_nxt = dec[OP_ISZ] ? ST_T6 : ST_T0;
            ST_T6:   st_nxt = ST_T0;
            default: st_nxt = ST_T0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_T0;
        else     st <= st_nxt;
    end

    p_fetch_order_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_T0) |=> (st == ST_T1));
    p_decode_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_T1) |=> (st == ST_T2));
    p_t6_wrap_r13: assert property (@(posedge clk) disable iff (rst)
        (st == ST_T6) |=> (st == ST_T0));
endmodule

// File: rtl/acc_word_mem.sv
module acc_word_mem #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/acc_io_port.sv
module acc_io_port #(
    parameter int IOW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [IOW-1:0] in_byte,
    input  logic           out_ack,
    input  logic           take_in,
    input  logic           give_out,
    input  logic [IOW-1:0] ac_lo,
    output logic [IOW-1:0] inpr,
    output logic [IOW-1:0] outr,
    output logic           fgi,
    output logic           fgo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            inpr <= '0;
            outr <= '0;
            fgi  <= 1'b0;
            fgo  <= 1'b0;
        end else begin
            if (in_valid) begin
                inpr <= in_byte;
                fgi  <= 1'b1;
            end else if (take_in) begin
                fgi  <= 1'b0;
            end
            if (give_out) outr <= ac_lo;
            if (out_ack)       fgo <= 1'b1;
            else if (give_out) fgo <= 1'b0;
        end
    end

    p_fgi_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (take_in && !in_valid) |=> !fgi);
    p_fgo_set_r10: assert property (@(posedge clk) disable iff (rst)
        out_ack |=> fgo);
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
    import acc_seq_pkg::*;
#(
    parameter int DW  = 16,
    parameter int AW  = 8,
    parameter int IOW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pre_we,
    input  logic [AW-1:0]       pre_addr,
    input  logic [DW-1:0]       pre_data,
    input  logic [AW-1:0]       peek_addr,
    output logic [DW-1:0]       peek_data,
    input  logic                in_valid,
    input  logic [IOW-1:0]      in_byte,
    input  logic                out_ack,
    output logic [IOW-1:0]      out_byte,
    output logic                in_flag,
    output logic                out_flag,
    output logic [DW-1:0]       ac_q,
    output logic [DW-OPW-2:0]   pc_q,
    output logic                e_q,
    output logic                ien_q,
    output logic                fetch_q
);
    localparam int AFW  = DW - 1 - OPW;
    localparam int PADW = DW - AFW;

    seq_t            st;
    logic [AFW-1:0]  ar, pc;
    logic [DW-1:0]   dr, ac, ir;
    logic            e, ibit, ien;
    logic [NDEC-1:0] dec;
    logic [DW-1:0]   mem_rd, core_wd, mem_wd;
    logic            core_we, mem_we;
    logic [AW-1:0]   mem_wa;
    logic [DW:0]     add_full;
    logic [IOW-1:0]  inpr;
    logic            fgi, fgo;
    logic            io_step, take_in, give_out, skip_io;

    acc_seq_ctrl ctrl_i (
        .clk (clk),
        .rst (rst),
        .dec (dec),
        .st  (st)
    );

    acc_word_mem #(.DW(DW), .AW(AW)) mem_i (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_wa),
        .wdata   (mem_wd),
        .raddr_a (ar[AW-1:0]),
        .rdata_a (mem_rd),
        .raddr_b (peek_addr),
        .rdata_b (peek_data)
    );

    acc_io_port #(.IOW(IOW)) io_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .out_ack  (out_ack),
        .take_in  (take_in),
        .give_out (give_out),
        .ac_lo    (ac[IOW-1:0]),
        .inpr     (inpr),
        .outr     (out_byte),
        .fgi      (fgi),
        .fgo      (fgo)
    );

    always_comb begin
        io_step  = (st == ST_T3) && dec[OP_EXT] && ibit;
        take_in  = io_step && ir[IO_INP];
        give_out = io_step && ir[IO_OUT];
        skip_io  = (ir[IO_SKI] && fgi) || (ir[IO_SKO] && fgo);
        core_we  = ((st == ST_T4) && (dec[OP_STA] || dec[OP_CAL]))
                || ((st == ST_T6) && dec[OP_ISZ]);
        if (dec[OP_STA])      core_wd = ac;
        else if (dec[OP_CAL]) core_wd = {{PADW{1'b0}}, pc};
        else                  core_wd = dr;
        mem_we   = rst ? pre_we   : core_we;
        mem_wa   = rst ? pre_addr : ar[AW-1:0];
        mem_wd   = rst ? pre_data : core_wd;
        add_full = {1'b0, ac} + {1'b0, dr};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ar   <= '0;
            pc   <= '0;
            dr   <= '0;
            ac   <= '0;
            ir   <= '0;
            e    <= 1'b0;
            ibit <= 1'b0;
            ien  <= 1'b0;
            dec  <= '0;
        end else begin
            unique case (st)
                ST_T0: ar <= pc;
                ST_T1: begin
                    ir <= mem_rd;
                    pc <= pc + 1'b1;
                end
                ST_T2: begin
                    dec  <= NDEC'(1) << ir[DW-2 -: OPW];
                    ar   <= ir[AFW-1:0];
                    ibit <= ir[DW-1];
                end
                ST_T3: begin
                    if (!dec[OP_EXT] && ibit) begin
                        ar <= mem_rd[AFW-1:0];
                    end else if (io_step) begin
                        if (ir[IO_INP]) ac[IOW-1:0] <= inpr;
                        if (ir[IO_ION]) ien <= 1'b1;
                        pc <= pc + AFW'(skip_io);
                    end
                end
                ST_T4: begin
                    if (dec[OP_AND] || dec[OP_ADD] || dec[OP_LDA] || dec[OP_ISZ])
                        dr <= mem_rd;
                    if (dec[OP_JMP]) pc <= ar;
                    if (dec[OP_CAL]) ar <= ar + 1'b1;
                end
                ST_T5: begin
                    if (dec[OP_AND]) ac <= ac & dr;
                    if (dec[OP_ADD]) {e, ac} <= add_full;
                    if (dec[OP_LDA]) ac <= dr;
                    if (dec[OP_CAL]) pc <= ar;
                    if (dec[OP_ISZ]) dr <= dr + 1'b1;
                end
                ST_T6: begin
                    if (dec[OP_ISZ] && (dr == '0)) pc <= pc + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ac_q     = ac;
    assign pc_q     = pc;
    assign e_q      = e;
    assign ien_q    = ien;
    assign in_flag  = fgi;
    assign out_flag = fgo;
    assign fetch_q  = (st == ST_T0);

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_T1) |=> (pc == $past(pc) + 1'b1));
    p_dec_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_T3) |-> ($countones(dec) == 1));
    p_regref_nop_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_T3 && dec[OP_EXT] && !ibit) |=> (pc == $past(pc) && ac == $past(ac)));
    p_ien_hold_r12: assert property (@(posedge clk) disable iff (rst)
        ien |=> ien);
endmodule

// File: tb/acc_seq_core_tb.sv
module acc_seq_core_tb_top;
    localparam int DW = 16, AW = 8, IOW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [DW-1:0] pre_data = '0;
    logic [AW-1:0] peek_addr = '0;
    logic [DW-1:0] peek_data;
    logic in_valid = 1'b0;
    logic [IOW-1:0] in_byte = '0;
    logic out_ack = 1'b0;
    logic [IOW-1:0] out_byte;
    logic in_flag, out_flag, e_q, ien_q, fetch_q;
    logic [DW-1:0] ac_q;
    logic [DW-5:0] pc_q;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    acc_seq_core #(.DW(DW), .AW(AW), .IOW(IOW)) dut_i (
        .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .peek_addr(peek_addr), .peek_data(peek_data),
        .in_valid(in_valid), .in_byte(in_byte), .out_ack(out_ack),
        .out_byte(out_byte), .in_flag(in_flag), .out_flag(out_flag),
        .ac_q(ac_q), .pc_q(pc_q), .e_q(e_q), .ien_q(ien_q), .fetch_q(fetch_q)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic enter_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic run(input int n);
        rst = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
        return dut_i.mem_i.cells[a];
    endfunction

    task automatic peek_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        peek_addr = a;
        #1;
        check(tag, peek_data, exp);
    endtask

    task automatic t_reset();
        enter_reset();
        check("R1 pc cleared", pc_q, 0);
        check("R1 ac cleared", ac_q, 0);
        check("R1 carry cleared", e_q, 0);
        check("R1 ien cleared", ien_q, 0);
        check("R1 in flag cleared", in_flag, 0);
        check("R1 out flag cleared", out_flag, 0);
        check("R1 at fetch step", fetch_q, 1);
    endtask

    task automatic t_arith();
        enter_reset();
        poke(0, 16'h2010); poke(1, 16'h1011); poke(2, 16'h0012);
        poke(8'h10, 16'hFFF0); poke(8'h11, 16'h0015); poke(8'h12, 16'h0F0C);
        run(6);
        check("R3 LOAD ac", ac_q, 16'hFFF0);
        check("R3 LOAD 6 cycles", fetch_q, 1);
        check("R2 pc after one fetch", pc_q, 1);
        run(6);
        check("R3 ADD sum", ac_q, 16'h0005);
        check("R3 ADD carry", e_q, 1);
        check("R3 ADD 6 cycles", fetch_q, 1);
        run(6);
        check("R3 AND result", ac_q, 16'h0004);
        check("R3 AND keeps carry", e_q, 1);
        check("R2 pc after three", pc_q, 3);
    endtask

    task automatic t_indirect();
        enter_reset();
        poke(0, 16'hA020); poke(8'h20, 16'h0030); poke(8'h30, 16'h1234);
        run(6);
        check("R4 indirect LOAD operand", ac_q, 16'h1234);
        check("R4 indirect 6 cycles", fetch_q, 1);
    endtask

    task automatic t_store_jump();
        enter_reset();
        poke(0, 16'h2010); poke(1, 16'h3011); poke(2, 16'h4040);
        poke(8'h10, 16'hBEEF); poke(8'h11, 16'h0000);
        run(6);
        run(5);
        peek_chk("R5 STORE wrote ac", 8'h11, 16'hBEEF);
        check("R5 STORE 5 cycles", fetch_q, 1);
        check("R5 STORE pc", pc_q, 2);
        run(5);
        check("R5 JUMP pc", pc_q, 12'h040);
        check("R5 JUMP 5 cycles", fetch_q, 1);
    endtask

    task automatic t_call();
        enter_reset();
        poke(0, 16'h5050); poke(8'h50, 16'h0000);
        run(6);
        peek_chk("R6 CALL return address", 8'h50, 16'h0001);
        check("R6 CALL pc", pc_q, 12'h051);
        check("R6 CALL 6 cycles", fetch_q, 1);
    endtask

    task automatic t_isz();
        enter_reset();
        poke(0, 16'h6060); poke(1, 16'h7000); poke(2, 16'h6061);
        poke(8'h60, 16'hFFFF); poke(8'h61, 16'h0005);
        run(7);
        peek_chk("R7 ISZ wrap writes zero", 8'h60, 16'h0000);
        check("R7 ISZ zero skips", pc_q, 2);
        check("R7 ISZ 7 cycles", fetch_q, 1);
        run(7);
        peek_chk("R7 ISZ increments", 8'h61, 16'h0006);
        check("R7 ISZ nonzero no skip", pc_q, 3);
    endtask

    task automatic t_regref();
        enter_reset();
        poke(0, 16'h2010); poke(1, 16'h7FFF); poke(8'h10, 16'h00AA);
        run(6);
        run(4);
        check("R8 no-op keeps ac", ac_q, 16'h00AA);
        check("R8 no-op keeps carry", e_q, 0);
        check("R8 no-op pc", pc_q, 2);
        check("R8 no-op 4 cycles", fetch_q, 1);
    endtask

    task automatic t_input();
        enter_reset();
        poke(0, 16'h2010); poke(1, 16'hF200); poke(2, 16'hF800);
        poke(3, 16'hF200); poke(4, 16'h7000); poke(5, 16'h7000);
        poke(8'h10, 16'hAB00);
        run(6);
        check("R9 in flag idle", in_flag, 0);
        run(4);
        check("R11 SKI flag clear no skip", pc_q, 2);
        in_valid = 1'b1; in_byte = 8'h5C;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 strobe sets in flag", in_flag, 1);
        run(3);
        check("R9 INP low byte, high kept", ac_q, 16'hAB5C);
        check("R9 INP clears flag", in_flag, 0);
        check("R9 INP 4 cycles", fetch_q, 1);
        in_valid = 1'b1; in_byte = 8'h77;
        @(negedge clk);
        in_valid = 1'b0;
        run(3);
        check("R11 SKI flag set skips", pc_q, 5);
    endtask

    task automatic t_output();
        enter_reset();
        poke(0, 16'h2010); poke(1, 16'hF100); poke(2, 16'hF100);
        poke(3, 16'h7000); poke(4, 16'hF400); poke(5, 16'hF080);
        poke(8'h10, 16'h12C3);
        run(6);
        run(4);
        check("R11 SKO flag clear no skip", pc_q, 2);
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
        run(3);
        check("R11 SKO flag set skips", pc_q, 4);
        check("R10 ack sets out flag", out_flag, 1);
        check("R10 out idle value", out_byte, 8'h00);
        run(4);
        check("R10 OUT byte", out_byte, 8'hC3);
        check("R10 OUT clears flag", out_flag, 0);
        check("R12 ien before enable", ien_q, 0);
        run(4);
        check("R12 ION sets ien", ien_q, 1);
        check("R13 ION 4 cycles", fetch_q, 1);
        check("R12 pc after ION", pc_q, 6);
        run(8);
        check("R12 ien stays set", ien_q, 1);
        enter_reset();
        check("R1 reset clears ien", ien_q, 0);
        check("R1 reset clears pc", pc_q, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_arith();
        t_indirect();
        t_store_jump();
        t_call();
        t_isz();
        t_regref();
        t_input();
        t_output();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule